// File: doc/BRIEF.md
# Ripple Magnitude Comparator

This block compares two unsigned operands of the same width and reports whether the first is greater than, equal to, or less than the second. The result is not taken from a relational operator. It is formed by a chain of identical one-bit cells that runs from the most significant position down to the least significant. Each cell receives two flags from the cell above it, "already greater" and "still equal". It refines those flags using its own pair of bits and passes them to the cell below.

The first cell in the chain, at the most significant end, is seeded with "not greater" and "equal". The flags that leave the least significant cell are the final greater and equal results. Less-than is derived from those two flags. The block has no clock and no storage, so its outputs follow the operands within the same cycle. It fits anywhere that an unsigned ordering decision is needed inside a wider datapath.

Top module: `mag_compare`

## Requirements
- R1: A cell drives its greater flag high when the incoming greater flag is high. It also drives it high when the incoming equal flag is high and its a bit is 1 while its b bit is 0. In every other case the greater flag is low, so a decision made at a higher bit is never overturned by lower bits.
- R2: A cell drives its equal flag high only when the incoming equal flag is high and its a and b bits match. A mismatch at any position, including bit 0, clears equality.
- R3: The chain is seeded at bit WIDTH-1 with greater = 0 and equal = 1. As a result, gt_o is 1 exactly when a_i is greater than b_i as an unsigned number.
- R4: eq_o is 1 exactly when every bit of a_i equals the bit of b_i at the same position.
- R5: lt_o is 1 exactly when gt_o and eq_o are both 0.
- R6: For every operand pair, exactly one of gt_o, eq_o and lt_o is 1.
- R7: With WIDTH = 4, a_i = 4'b1101 and b_i = 4'b1011 give gt_o = 1, eq_o = 0 and lt_o = 0.
- R8: The block is purely combinational. Its outputs reflect the operands presented in the same cycle, with no register between the inputs and the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i  | input     | WIDTH | First unsigned operand |
| b_i  | input     | WIDTH | Second unsigned operand |
| gt_o | output    | 1     | High when a_i > b_i |
| eq_o | output    | 1     | High when a_i == b_i |
| lt_o | output    | 1     | High when a_i < b_i |

## Verification
Every result is due in the same cycle as its operands, with zero register stages. The driver applies a new operand pair on a rising clock edge and queues the expected flags. The monitor compares the outputs at the following falling edge, half a period later, which is before the next pair is applied. Because exactly one item is ever outstanding, a result that lags by one stage would be compared against the wrong pair and reported. The full set of 256 pairs at the default width is covered, together with directed pairs in which the deciding bit is the most significant one or the least significant one.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

    // Flags carried from one bit cell to the next, most significant first.
    typedef struct packed {
        logic gt;   // a already proven larger at a higher bit
        logic eq;   // all higher bits matched so far
    } rank_t;

    localparam rank_t RANK_SEED = '{gt: 1'b0, eq: 1'b1};

endpackage

// File: rtl/cmp_bit_slice.sv
module cmp_bit_slice
    import mag_cmp_pkg::*;
(
    input  rank_t rank_i,
    input  logic  a_bit,
    input  logic  b_bit,
    output rank_t rank_o
);

    rank_t rank_d;

    always_comb begin
        rank_d.gt = rank_i.gt | (rank_i.eq & a_bit & ~b_bit);
        rank_d.eq = rank_i.eq & ~(a_bit ^ b_bit);
    end

    assign rank_o = rank_d;

    // A decision from above survives; equality cannot be created from nothing.
    always_comb begin
        if (!$isunknown({rank_i, a_bit, b_bit})) begin
            AST_GT_KEPT: assert (!rank_i.gt || rank_o.gt) else $error("greater flag lost");       // R1
            AST_EQ_NEEDS_IN: assert (rank_i.eq || !rank_o.eq) else $error("equal raised");         // R2
            AST_EQ_MISMATCH: assert (a_bit == b_bit || !rank_o.eq) else $error("equal on mismatch"); // R2
        end
    end

endmodule

// File: rtl/cmp_ripple_chain.sv
module cmp_ripple_chain
    import mag_cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output rank_t            rank_o
);

    localparam int LINKS = WIDTH + 1;

    rank_t link_q [LINKS];

    assign link_q[WIDTH] = RANK_SEED;

    for (genvar g = WIDTH - 1; g >= 0; g--) begin : g_cell
        cmp_bit_slice i_cell (
            .rank_i (link_q[g+1]),
            .a_bit  (a_i[g]),
            .b_bit  (b_i[g]),
            .rank_o (link_q[g])
        );
    end

    assign rank_o = link_q[0];

endmodule

// File: rtl/cmp_resolve.sv
module cmp_resolve
    import mag_cmp_pkg::*;
(
    input  rank_t rank_i,
    output logic  gt_o,
    output logic  eq_o,
    output logic  lt_o
);

    logic lt_d;

    always_comb begin
        lt_d = ~(rank_i.gt | rank_i.eq);
    end

    assign gt_o = rank_i.gt;
    assign eq_o = rank_i.eq;
    assign lt_o = lt_d;

endmodule

// File: rtl/mag_compare.sv
module mag_compare
    import mag_cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             gt_o,
    output logic             eq_o,
    output logic             lt_o
);

    rank_t final_rank;

    cmp_ripple_chain #(.WIDTH(WIDTH)) i_chain (
        .a_i    (a_i),
        .b_i    (b_i),
        .rank_o (final_rank)
    );

    cmp_resolve i_resolve (
        .rank_i (final_rank),
        .gt_o   (gt_o),
        .eq_o   (eq_o),
        .lt_o   (lt_o)
    );

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            AST_ONE_RESULT: assert ($countones({gt_o, eq_o, lt_o}) == 1) else $error("not one-hot"); // R6
            AST_GT_ORDER: assert (gt_o == (a_i > b_i)) else $error("gt wrong");                        // R3
            AST_EQ_ORDER: assert (eq_o == (a_i == b_i)) else $error("eq wrong");                       // R4
            AST_LT_ORDER: assert (lt_o == (a_i < b_i)) else $error("lt wrong");                        // R5
        end
    end

endmodule

// File: tb/test_mag_compare.sv
module test_mag_compare;

    localparam int WIDTH = 4;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG_CYCLES = 5000;

    typedef struct {
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic gt;
        logic eq;
        logic lt;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic [WIDTH-1:0] a_i = '0;
    logic [WIDTH-1:0] b_i = '0;
    logic gt_o, eq_o, lt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mag_compare #(.WIDTH(WIDTH)) i_mag_compare (
        .a_i  (a_i),
        .b_i  (b_i),
        .gt_o (gt_o),
        .eq_o (eq_o),
        .lt_o (lt_o)
    );

    task automatic check_bit(string req, string what, logic act, logic exp,
                             logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s a=%b b=%b actual=%b expected=%b", req, what, a, b, act, exp);
        end
    endtask

    // Driver: apply operands on a rising edge and queue the reference result.
    task automatic drive(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, string tag);
        item_t it;
        @(posedge clk);
        a_i = a;
        b_i = b;
        it.a = a;
        it.b = b;
        it.gt = (a > b);
        it.eq = (a == b);
        it.lt = (a < b);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: zero register stages (R8), so compare at the next falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check_bit(it.tag, "gt R3", gt_o, it.gt, it.a, it.b);
            check_bit(it.tag, "eq R4", eq_o, it.eq, it.a, it.b);
            check_bit(it.tag, "lt R5", lt_o, it.lt, it.a, it.b);
            check_bit(it.tag, "onehot R6",
                      logic'($countones({gt_o, eq_o, lt_o}) == 1), 1'b1, it.a, it.b);
        end
    end

    initial begin
        // Both operands at zero: equal (R4).
        drive(4'b0000, 4'b0000, "R4_zero");
        // Worked example (R7).
        drive(4'b1101, 4'b1011, "R7_example");
        // MSB decides, lower bits would say the opposite (R1).
        drive(4'b1000, 4'b0111, "R1_msb_gt");
        drive(4'b0111, 4'b1000, "R1_msb_lt");
        // Only bit 0 differs, so equality is cleared at the last cell (R2).
        drive(4'b0101, 4'b0100, "R2_lsb_gt");
        drive(4'b1110, 4'b1111, "R2_lsb_lt");
        drive(4'b1111, 4'b1111, "R4_ones");
        // Operands change every cycle and each result is due at once (R8).
        drive(4'b0001, 4'b0010, "R8_back2back");
        drive(4'b0010, 4'b0001, "R8_back2back");
        // Every pair at the default width (R3, R4, R5, R6).
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive(WIDTH'(i), WIDTH'(j), "R3_sweep");
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYCLES; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=running expected=done");
        end
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R8 queue actual=%0d expected=0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule